// File: doc/BRIEF.md
# Inter-processor message mailbox with per-user interrupts

This block is a memory-mapped message exchange between processors on one chip. It holds a set of small hardware FIFOs, one for each mailbox, and each FIFO stores 32-bit words. A sender writes a word to a mailbox's message register, which pushes the word into that FIFO. A receiver reads the same register, which pops the oldest word. Each mailbox also has a full flag and a word count, so software can poll without disturbing the queue.

Every processor (user) has its own pair of interrupt registers and its own interrupt line. Mailbox events are posted to every user's status register. Each user's enable mask then decides which of those events raise that user's line. A status bit is acknowledged by writing one to it.

A configuration register can start a soft reset. The soft reset empties every FIFO and clears all interrupt state over a fixed number of cycles, and a status register reports when the soft reset has finished. A read-only revision register identifies the block.

Top module: `ipc_mailbox`

## Requirements
- R1: After hardware reset, the revision word at byte 0x000 reads {major in bits 7:4, minor in bits 3:0}, the reset-status word at 0x014 reads 1, every count reads 0 and every interrupt line is low.
- R2: A write to the message register of mailbox m (0x040 + 4*m) appends the word to that FIFO. A read of the same register returns the words in the order they were written. The count register at 0x0C0 + 4*m returns the number of words held.
- R3: The full flag at 0x080 + 4*m reads 1 when mailbox m holds DEPTH words and reads 0 otherwise. A write to a full mailbox is dropped: the count, the contents and the interrupt status do not change.
- R4: A read of an empty mailbox's message register returns 0 and changes no count and no status bit.
- R5: Each accepted write to mailbox m sets bit 2*m in the status register of every user.
- R6: A read that takes mailbox m from full to not full sets bit 2*m+1 in the status register of every user. A read from a mailbox that was not full sets no bit.
- R7: The status register of user u is at 0x100 + 8*u. Writing 1 to a bit of it clears that bit, and writing 0 leaves the bit unchanged.
- R8: The enable register of user u is at 0x104 + 8*u. Interrupt line u is high exactly when some bit is set in both user u's status and user u's enable.
- R9: Writing the configuration register at 0x010 with bit 1 set starts a soft reset. While it runs, bit 1 of the configuration register reads 1 and the reset-status word reads 0. After RST_CYCLES cycles, all FIFOs are empty, all status, enable and stored configuration bits are 0, and the reset-status word reads 1.
- R10: Writes to the configuration register without bit 1 store bits 0, 3 and 4 and discard the rest. Unmapped or misaligned addresses read 0. Writes to read-only registers have no effect.
- R11: Read data appears on the data output in the cycle after the read strobe. Events and interrupt lines update at the clock edge that accepts the write or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe; takes priority over a read in the same cycle |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd |
| user_irq | output | NUM_USER | One interrupt line per user |

## Verification
Read data is due one clock edge after the read strobe is sampled. The scoreboard monitor therefore records the strobe at each rising edge and compares the output one nanosecond later against the value the driver queued. Status bits and interrupt lines change at the same edge that accepts the write or pop, so the bench samples interrupt lines at the falling edge that follows the access. The soft-reset word is read first in the cycle right after the request, where it must show busy. It is read again after more than RST_CYCLES cycles, where it must show done.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic [3:0] {
      RG_NONE, RG_REV, RG_CFG, RG_STS, RG_MSG, RG_FULL, RG_CNT, RG_IST, RG_IEN
   } mbx_region_e;

   typedef struct packed {
      mbx_region_e region;
      logic [3:0]  idx;
   } mbx_decode_t;

   localparam int CFG_START_BIT = 1;
   localparam logic [31:0] CFG_KEEP_MASK = 32'h0000_0019;

   // word index = byte address / 4
   function automatic mbx_decode_t mbx_decode(input logic [6:0] w, input int n_mbox,
                                              input int n_user);
      mbx_decode_t d;
      d.region = RG_NONE;
      d.idx    = w[3:0];
      if (w == 7'd0)      d.region = RG_REV;
      else if (w == 7'd4) d.region = RG_CFG;
      else if (w == 7'd5) d.region = RG_STS;
      else if (w[6:4] == 3'b001 && int'(w[3:0]) < n_mbox) d.region = RG_MSG;
      else if (w[6:4] == 3'b010 && int'(w[3:0]) < n_mbox) d.region = RG_FULL;
      else if (w[6:4] == 3'b011 && int'(w[3:0]) < n_mbox) d.region = RG_CNT;
      else if (w[6:3] == 4'b1000 && int'(w[2:1]) < n_user) begin
         d.idx    = {2'b00, w[2:1]};
         d.region = w[0] ? RG_IEN : RG_IST;
      end
      return d;
   endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          push,
   input  logic                          pop,
   input  logic [DW-1:0]                 wdata,
   output logic [DW-1:0]                 head,
   output logic                          full,
   output logic                          empty,
   output logic [$clog2(DEPTH+1)-1:0]    count,
   output logic                          push_ok,
   output logic                          leave_full
);
   localparam int CW = $clog2(DEPTH+1);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic          pop_ok;

   if (DEPTH < 2) begin : g_bad_depth
      $error("mbx_fifo: DEPTH must be at least 2");
   end

   assign full       = (count == CW'(DEPTH));
   assign empty      = (count == '0);
   assign push_ok    = push & ~full & ~flush;
   assign pop_ok     = pop & ~empty & ~flush;
   assign leave_full = pop_ok & full;
   assign head       = empty ? '0 : mem[rp];

   if (POW2) begin : g_wrap_free
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_wrap_cmp
      assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push_ok) wp <= wp_nx;
         if (pop_ok)  rp <= rp_nx;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= wdata;
   end

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));
   a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> (count == '0));

endmodule

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
   parameter int EW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_all,
   input  logic [EW-1:0] set_ev,
   input  logic          wr_status,
   input  logic          wr_enable,
   input  logic [EW-1:0] wdata,
   output logic [EW-1:0] status,
   output logic [EW-1:0] enable,
   output logic          irq
);
   logic [EW-1:0] clr_mask;

   assign clr_mask = wr_status ? wdata : '0;
   assign irq      = |(status & enable);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         enable <= '0;
      end else if (clear_all) begin
         status <= '0;
         enable <= '0;
      end else begin
         status <= (status & ~clr_mask) | set_ev;
         if (wr_enable) enable <= wdata;
      end
   end

   a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && !clear_all && set_ev == '0) |=> ((status & $past(wdata)) == '0));
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_all && !wr_status) |=> ((status & $past(status)) == $past(status)));
   a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_all && set_ev != '0) |=> ((status & $past(set_ev)) == $past(set_ev)));

endmodule

// File: rtl/mbx_srst.sv
module mbx_srst #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("mbx_srst: CYCLES must be at least 1");
   end

   assign busy = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b1;
      end else if (start) begin
         cnt  <= CNT_W'(CYCLES);
         done <= 1'b0;
      end else if (busy) begin
         cnt <= cnt - 1'b1;
         if (cnt == CNT_W'(1)) done <= 1'b1;
      end
   end

   a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   a_r9_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
   parameter int ADDR_W     = 9,
   parameter int NUM_MBOX   = 4,
   parameter int NUM_USER   = 2,
   parameter int DEPTH      = 4,
   parameter int RST_CYCLES = 4,
   parameter int REV_MAJOR  = 2,
   parameter int REV_MINOR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NUM_USER-1:0] user_irq
);
   import mbx_pkg::*;

   localparam int EW = 2 * NUM_MBOX;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [31:0] REV_WORD = {24'h0, 4'(REV_MAJOR), 4'(REV_MINOR)};

   if (ADDR_W < 9) begin : g_bad_aw
      $error("ipc_mailbox: ADDR_W must be at least 9");
   end
   if (NUM_MBOX < 1 || NUM_MBOX > 16) begin : g_bad_mbox
      $error("ipc_mailbox: NUM_MBOX must be 1..16");
   end
   if (NUM_USER < 1 || NUM_USER > 4) begin : g_bad_user
      $error("ipc_mailbox: NUM_USER must be 1..4");
   end
   if (REV_MAJOR > 15 || REV_MINOR > 15) begin : g_bad_rev
      $error("ipc_mailbox: revision fields are 4 bits");
   end

   // ---------------- decode ----------------
   logic        addr_ok;
   mbx_decode_t dec;
   logic        busy, done;
   logic        wr_act, rd_act;

   if (ADDR_W > 9) begin : g_hi_addr
      assign addr_ok = (reg_addr[1:0] == 2'b00) && (reg_addr[ADDR_W-1:9] == '0);
   end else begin : g_no_hi_addr
      assign addr_ok = (reg_addr[1:0] == 2'b00);
   end

   always_comb begin
      dec = mbx_decode(reg_addr[8:2], NUM_MBOX, NUM_USER);
      if (!addr_ok) dec.region = RG_NONE;
   end

   assign wr_act = reg_wr & ~busy;
   assign rd_act = reg_rd & ~reg_wr;

   // ---------------- configuration / soft reset ----------------
   logic [31:0] cfg_keep;
   logic        srst_start;

   assign srst_start = wr_act && dec.region == RG_CFG && reg_wdata[CFG_START_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cfg_keep <= '0;
      else if (srst_start)                       cfg_keep <= '0;
      else if (wr_act && dec.region == RG_CFG)   cfg_keep <= reg_wdata & CFG_KEEP_MASK;
   end

   mbx_srst #(.CYCLES(RST_CYCLES)) u_srst (
      .clk  (clk),
      .rst_n(rst_n),
      .start(srst_start),
      .busy (busy),
      .done (done)
   );

   // ---------------- mailbox FIFOs ----------------
   logic [31:0]   head_a  [NUM_MBOX];
   logic [CW-1:0] cnt_a   [NUM_MBOX];
   logic [NUM_MBOX-1:0] full_v, empty_v, push_v, pop_v;
   logic [EW-1:0] ev;

   for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
      logic p_ok, l_full;
      assign push_v[m] = wr_act && dec.region == RG_MSG && int'(dec.idx) == m;
      assign pop_v[m]  = rd_act && dec.region == RG_MSG && int'(dec.idx) == m;

      mbx_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (busy),
         .push      (push_v[m]),
         .pop       (pop_v[m]),
         .wdata     (reg_wdata),
         .head      (head_a[m]),
         .full      (full_v[m]),
         .empty     (empty_v[m]),
         .count     (cnt_a[m]),
         .push_ok   (p_ok),
         .leave_full(l_full)
      );
      assign ev[2*m]   = p_ok;
      assign ev[2*m+1] = l_full;
   end

   // ---------------- per-user interrupt banks ----------------
   logic [EW-1:0] st_a [NUM_USER];
   logic [EW-1:0] en_a [NUM_USER];

   for (genvar u = 0; u < NUM_USER; u++) begin : g_user
      logic hit_u;
      assign hit_u = wr_act && int'(dec.idx) == u;
      mbx_irq_bank #(.EW(EW)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear_all(busy),
         .set_ev   (ev),
         .wr_status(hit_u && dec.region == RG_IST),
         .wr_enable(hit_u && dec.region == RG_IEN),
         .wdata    (reg_wdata[EW-1:0]),
         .status   (st_a[u]),
         .enable   (en_a[u]),
         .irq      (user_irq[u])
      );
   end

   // ---------------- read path ----------------
   logic [31:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      case (dec.region)
         RG_REV: rd_mux = REV_WORD;
         RG_CFG: rd_mux = cfg_keep | (32'(busy) << CFG_START_BIT);
         RG_STS: rd_mux = 32'(done);
         RG_MSG:  for (int i = 0; i < NUM_MBOX; i++) if (int'(dec.idx) == i) rd_mux = head_a[i];
         RG_FULL: for (int i = 0; i < NUM_MBOX; i++) if (int'(dec.idx) == i) rd_mux = 32'(full_v[i]);
         RG_CNT:  for (int i = 0; i < NUM_MBOX; i++) if (int'(dec.idx) == i) rd_mux = 32'(cnt_a[i]);
         RG_IST:  for (int i = 0; i < NUM_USER; i++) if (int'(dec.idx) == i) rd_mux = 32'(st_a[i]);
         RG_IEN:  for (int i = 0; i < NUM_USER; i++) if (int'(dec.idx) == i) rd_mux = 32'(en_a[i]);
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (rd_act) reg_rdata <= rd_mux;
   end

   a_r11_rev_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_wr && reg_addr == '0) |=> (reg_rdata == REV_WORD));
   a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (&empty_v));
   a_r4_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && dec.region == RG_MSG && (|(empty_v & (NUM_MBOX'(1) << dec.idx))))
      |=> (reg_rdata == '0));

endmodule

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
   localparam int AW = 9;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr, reg_rd;
   logic [AW-1:0] reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic [1:0]  user_irq;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];
   bit          mon_take;
   logic [31:0] mon_exp;
   string       mon_tag;

   always #2.5 clk = ~clk;

   ipc_mailbox #(.ADDR_W(AW), .NUM_MBOX(4), .NUM_USER(2), .DEPTH(4),
                 .RST_CYCLES(4), .REV_MAJOR(2), .REV_MINOR(1)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .user_irq(user_irq)
   );

   // monitor: read data is due one edge after the strobe (R11)
   always @(posedge clk) begin
      mon_take = reg_rd & ~reg_wr & rst_n;
      #1;
      if (mon_take && exp_q.size() > 0) begin
         mon_exp = exp_q.pop_front();
         mon_tag = tag_q.pop_front();
         n_cmp++;
         if (reg_rdata !== mon_exp) begin
            n_bad++;
            $display("FAIL %s: read got %h expected %h", mon_tag, reg_rdata, mon_exp);
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
      reg_rd = 1'b1; reg_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
      n_cmp++;
      if (got !== e) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", t, got, e);
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(32'(user_irq), 32'h0, "R1 irq after reset");
      rd(9'h000, 32'h21, "R1 revision");
      rd(9'h014, 32'h1, "R1 reset done");
      rd(9'h0C0, 32'h0, "R1 count mb0");

      // R5 / R8 new-message event and interrupt
      wr(9'h104, 32'h1);
      wr(9'h040, 32'hA1);
      chk(32'(user_irq[0]), 1, "R8 irq0 on enabled new-message");
      chk(32'(user_irq[1]), 0, "R8 irq1 masked");
      rd(9'h100, 32'h1, "R5 status user0");
      rd(9'h108, 32'h1, "R5 status user1");

      // R7 write-one-to-clear
      wr(9'h100, 32'h0);
      rd(9'h100, 32'h1, "R7 write zero keeps bit");
      wr(9'h100, 32'h1);
      rd(9'h100, 32'h0, "R7 write one clears bit");
      chk(32'(user_irq[0]), 0, "R8 irq0 after ack");

      // R2 / R3 fill to full, drop overflow
      wr(9'h040, 32'hA2);
      wr(9'h040, 32'hA3);
      wr(9'h040, 32'hA4);
      rd(9'h0C0, 32'h4, "R2 count four");
      rd(9'h080, 32'h1, "R3 full flag set");
      wr(9'h100, 32'h1);
      wr(9'h040, 32'hA5);
      rd(9'h0C0, 32'h4, "R3 overflow dropped count");
      rd(9'h100, 32'h0, "R3 overflow raises no event");

      // R2 / R6 drain
      rd(9'h040, 32'hA1, "R2 pop first");
      rd(9'h080, 32'h0, "R3 full flag clear");
      rd(9'h100, 32'h2, "R6 not-full event from full");
      wr(9'h100, 32'h2);
      rd(9'h040, 32'hA2, "R2 pop second");
      rd(9'h100, 32'h0, "R6 no event when not from full");
      rd(9'h040, 32'hA3, "R2 pop third");
      rd(9'h040, 32'hA4, "R2 pop fourth, overflow word absent");

      // R4 empty read
      rd(9'h040, 32'h0, "R4 empty pop returns zero");
      rd(9'h0C0, 32'h0, "R4 count stays zero");
      rd(9'h100, 32'h0, "R4 no status change");

      // second mailbox, per-user masks
      wr(9'h048, 32'hB0);
      rd(9'h108, 32'h13, "R5 R6 user1 accumulated status");
      chk(32'(user_irq[0]), 0, "R8 irq0 masked for mb2");
      wr(9'h10C, 32'h10);
      chk(32'(user_irq[1]), 1, "R8 irq1 enabled mb2");
      rd(9'h0C8, 32'h1, "R2 count mb2");
      rd(9'h0C0, 32'h0, "R2 mb0 independent");

      // R10 unmapped / read-only
      rd(9'h020, 32'h0, "R10 unmapped hole");
      rd(9'h118, 32'h0, "R10 absent user");
      rd(9'h041, 32'h0, "R10 misaligned");
      wr(9'h000, 32'hFF);
      rd(9'h000, 32'h21, "R10 revision read-only");
      rd(9'h0C8, 32'h1, "R10 misaligned read did not pop");
      wr(9'h010, 32'hFF_FFFD);
      rd(9'h010, 32'h19, "R10 config keeps bits 0,3,4");

      // R9 soft reset
      wr(9'h010, 32'h2);
      rd(9'h014, 32'h0, "R9 done low while busy");
      rd(9'h010, 32'h2, "R9 start bit reads busy");
      repeat (6) @(negedge clk);
      rd(9'h014, 32'h1, "R9 done after sequence");
      rd(9'h010, 32'h0, "R9 config cleared");
      rd(9'h0C8, 32'h0, "R9 fifo flushed");
      rd(9'h108, 32'h0, "R9 status cleared");
      rd(9'h10C, 32'h0, "R9 enable cleared");
      chk(32'(user_irq), 32'h0, "R9 irq low after soft reset");

      // FIFO operates after soft reset
      wr(9'h044, 32'hC0);
      rd(9'h044, 32'hC0, "R2 mb1 after soft reset");

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule